// File: doc/BRIEF.md
# EEPROM Page Write Engine

This block sits behind the serial-bus slave front end of a byte-addressable nonvolatile memory. It collects the data bytes of one write command into a page buffer. It waits for the bus STOP and then runs a single timed internal write cycle. At the end of that cycle it transfers every buffered byte to the memory array. The front end supplies a command-start strobe, the word address, complete data bytes and the STOP strobe. A free-running timebase supplies ticks. The array port is a plain write enable with an address and data.

Within one command the byte pointer advances only through the low page-offset bits. The page number taken from the word address never changes, so a command that starts near the end of a page wraps around to the page's first byte. If a command sends more bytes than the page holds, the later bytes replace the earlier ones at the wrapped positions. Busy tells the front end to refuse new commands until the cycle is over.

The write-protect input is ignored until the first data byte of a command is complete. From that point until the internal cycle ends, a high write-protect cancels the pending write or aborts the running cycle. An aborted cycle returns to standby at once, without waiting out the full cycle time.

Top module: `page_write_engine`

## Requirements
- R1: After reset, busy_o is low and arr_we_o stays low until a command has been accepted.
- R2: The first data byte goes to the word address from addr_i. Each further byte goes to the next offset, counting modulo the page size in the low PAGE_W bits. The upper address bits keep the page taken from addr_i, so a start at offset PAGE-2 writes PAGE-2, PAGE-1, 0, 1.
- R3: When more than PAGE bytes arrive in one command, each byte overwrites the byte held at its wrapped offset, and only the last value at each offset is written.
- R4: Only the offsets that received a byte in the command are written. Every other location of the array keeps its value.
- R5: A STOP that follows no complete data byte starts no write. A new start_i discards any bytes already buffered. In both cases busy_o stays low.
- R6: busy_o rises in the cycle after an accepted STOP. The array writes begin only after TWR_TICKS timebase ticks have been seen while busy, whatever the byte count. busy_o falls once the last page offset has been visited.
- R7: If wp_i is high in the cycle of the first data byte strobe, or in any later cycle up to and including the STOP, the command is cancelled: busy_o stays low and nothing is written.
- R8: A high wp_i between start_i and the first data byte strobe has no effect on the write.
- R9: A high wp_i while busy_o is high ends the cycle: busy_o falls in the next cycle and no further array write occurs.
- R10: start_i, addr_vld_i, data_vld_i and stop_i are ignored while busy_o is high, and so they do not change what is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Command start strobe, one cycle |
| addr_vld_i | input | 1 | Word address valid strobe |
| addr_i | input | ADDR_W | Word address (page and offset) |
| data_vld_i | input | 1 | Complete data byte strobe |
| data_i | input | DATA_W | Data byte |
| stop_i | input | 1 | STOP received strobe |
| wp_i | input | 1 | Write protect, high blocks or aborts writing |
| tick_i | input | 1 | Timebase tick, one cycle |
| arr_we_o | output | 1 | Array write enable |
| arr_addr_o | output | ADDR_W | Array write address |
| arr_data_o | output | DATA_W | Array write data |
| busy_o | output | 1 | Internal write cycle in progress |

## Verification
The bench builds the engine with 8-byte pages, a 7-bit address and a 4-tick cycle time. With those values the sweep covers every start offset paired with every byte count from one up to past a full page. This reaches all wrap points and all overwrite patterns, across 16 pages of an array model that can be checked whole. The short cycle time keeps each transaction to a few dozen clocks. Because of that, tick counts and busy timing can be checked on every transaction, along with the write-protect cases at each edge of the cancel window.

// File: rtl/pwe_pkg.sv
package pwe_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_FILL   = 2'd1,
    ST_WAIT   = 2'd2,
    ST_COMMIT = 2'd3
  } pwe_state_e;
endpackage

// File: rtl/pwe_page_latch.sv
module pwe_page_latch #(
  parameter int ADDR_W = 12,
  parameter int PAGE_W = 5,
  parameter int DATA_W = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     clr_i,
  input  logic                     load_i,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic                     wr_i,
  input  logic [DATA_W-1:0]        data_i,
  input  logic [PAGE_W-1:0]        rd_idx_i,
  output logic [ADDR_W-PAGE_W-1:0] page_o,
  output logic [(1<<PAGE_W)-1:0]   mask_o,
  output logic [DATA_W-1:0]        rd_data_o,
  output logic                     any_o
);
  localparam int PAGE = 1 << PAGE_W;
  localparam int PG_W = ADDR_W - PAGE_W;

  logic [PG_W-1:0]   page_q;
  logic [PAGE_W-1:0] ptr_q;
  logic [PAGE-1:0]   mask_q;
  logic [DATA_W-1:0] slot_q [PAGE];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      page_q <= '0;
      ptr_q  <= '0;
    end else if (load_i) begin
      page_q <= addr_i[ADDR_W-1:PAGE_W];
      ptr_q  <= addr_i[PAGE_W-1:0];
    end else if (wr_i) begin
      ptr_q  <= ptr_q + 1'b1;  // wraps inside the page, no carry upward
    end
  end

  for (genvar g = 0; g < PAGE; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        slot_q[g] <= '0;
        mask_q[g] <= 1'b0;
      end else if (clr_i) begin
        mask_q[g] <= 1'b0;
      end else if (wr_i && ptr_q == PAGE_W'(g)) begin
        slot_q[g] <= data_i;
        mask_q[g] <= 1'b1;
      end
    end
  end

  assign page_o    = page_q;
  assign mask_o    = mask_q;
  assign rd_data_o = slot_q[rd_idx_i];
  assign any_o     = |mask_q;

  // R5
  mask_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(any_o) |-> $past(clr_i));
endmodule

// File: rtl/pwe_wp_guard.sv
module pwe_wp_guard (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic open_i,
  input  logic wp_i,
  output logic cancel_o
);
  logic armed_q, cancel_q, hit;

  // window opens on the first complete data byte, inclusive
  assign hit = wp_i && (armed_q || open_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q  <= 1'b0;
      cancel_q <= 1'b0;
    end else if (clr_i) begin
      armed_q  <= 1'b0;
      cancel_q <= 1'b0;
    end else begin
      if (open_i) armed_q  <= 1'b1;
      if (hit)    cancel_q <= 1'b1;
    end
  end

  assign cancel_o = cancel_q || hit;

  // R7
  cancel_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cancel_q && !clr_i |=> cancel_q);
  // R8
  wp_early_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !armed_q && !open_i |-> !cancel_o);
endmodule

// File: rtl/pwe_cycle_timer.sv
module pwe_cycle_timer #(
  parameter int TWR_TICKS = 5000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic tick_i,
  output logic done_o
);
  localparam int CNT_W = (TWR_TICKS > 1) ? $clog2(TWR_TICKS) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TWR_TICKS - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (!run_i)           cnt_q <= '0;
    else if (tick_i && !done_o) cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = run_i && tick_i && (cnt_q == LAST);

  // R6
  tmr_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
endmodule

// File: rtl/page_write_engine.sv
module page_write_engine
  import pwe_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int PAGE_W    = 5,
  parameter int DATA_W    = 8,
  parameter int TWR_TICKS = 5000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              addr_vld_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              data_vld_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              stop_i,
  input  logic              wp_i,
  input  logic              tick_i,
  output logic              arr_we_o,
  output logic [ADDR_W-1:0] arr_addr_o,
  output logic [DATA_W-1:0] arr_data_o,
  output logic              busy_o
);
  localparam int PAGE = 1 << PAGE_W;
  localparam int PG_W = ADDR_W - PAGE_W;
  localparam logic [PAGE_W-1:0] IDX_LAST = PAGE_W'(PAGE - 1);

  pwe_state_e        state_q, state_d;
  logic [PAGE_W-1:0] idx_q;
  logic              in_cmd, busy;
  logic              clr, load, wr, open;
  logic              cancel, done;
  logic [PG_W-1:0]   page;
  logic [PAGE-1:0]   mask;
  logic [DATA_W-1:0] rd_data;
  logic              any;

  assign busy   = (state_q == ST_WAIT) || (state_q == ST_COMMIT);
  assign in_cmd = (state_q == ST_FILL);
  assign clr    = start_i && !busy;
  assign load   = in_cmd && addr_vld_i && !start_i;
  assign wr     = in_cmd && data_vld_i && !start_i;
  assign open   = wr && !any;

  pwe_page_latch #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .DATA_W(DATA_W)) u_latch (
    .clk_i, .rst_ni,
    .clr_i    (clr),
    .load_i   (load),
    .addr_i   (addr_i),
    .wr_i     (wr),
    .data_i   (data_i),
    .rd_idx_i (idx_q),
    .page_o   (page),
    .mask_o   (mask),
    .rd_data_o(rd_data),
    .any_o    (any)
  );

  pwe_wp_guard u_guard (
    .clk_i, .rst_ni,
    .clr_i   (clr),
    .open_i  (open),
    .wp_i    (wp_i),
    .cancel_o(cancel)
  );

  pwe_cycle_timer #(.TWR_TICKS(TWR_TICKS)) u_timer (
    .clk_i, .rst_ni,
    .run_i (state_q == ST_WAIT),
    .tick_i(tick_i),
    .done_o(done)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (start_i) state_d = ST_FILL;
      ST_FILL: begin
        if (start_i)     state_d = ST_FILL;
        else if (stop_i) state_d = (any && !cancel) ? ST_WAIT : ST_IDLE;
      end
      ST_WAIT: begin
        if (wp_i)      state_d = ST_IDLE;
        else if (done) state_d = ST_COMMIT;
      end
      ST_COMMIT: begin
        if (wp_i || idx_q == IDX_LAST) state_d = ST_IDLE;
      end
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_COMMIT) idx_q <= idx_q + 1'b1;
      else                      idx_q <= '0;
    end
  end

  assign arr_we_o   = (state_q == ST_COMMIT) && mask[idx_q] && !wp_i;
  assign arr_addr_o = {page, idx_q};
  assign arr_data_o = rd_data;
  assign busy_o     = busy;

  // R1
  rst_idle_chk: assert property (@(posedge clk_i)
    !rst_ni |=> !busy_o && !arr_we_o);
  // R6
  we_in_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arr_we_o |-> busy_o);
  // R6
  busy_from_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(stop_i));
  // R7
  no_busy_wp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> !$past(wp_i));
  // R9
  wp_abort_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && wp_i |=> !busy_o && !arr_we_o);
  // R2
  page_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && $past(busy_o) |-> $stable(arr_addr_o[ADDR_W-1:PAGE_W]));
endmodule

// File: tb/page_write_engine_bench.sv
module page_write_engine_bench;
  localparam int ADDR_W = 7;
  localparam int PAGE_W = 3;
  localparam int DATA_W = 8;
  localparam int TWR    = 4;
  localparam int PAGE   = 1 << PAGE_W;
  localparam int MEMSZ  = 1 << ADDR_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 0, addr_vld = 0, data_vld = 0, stop = 0, wp = 0, tick = 0;
  logic [ADDR_W-1:0] addr = '0;
  logic [DATA_W-1:0] data = '0;
  logic we, busy;
  logic [ADDR_W-1:0] waddr;
  logic [DATA_W-1:0] wdata;

  int checks = 0, failures = 0;
  int tick_seen = 0, last_ticks = 0, early_we = 0, div = 0, cycles = 0;
  logic [DATA_W-1:0] mem [MEMSZ];
  logic [DATA_W-1:0] exp_mem [MEMSZ];

  always #5 clk = ~clk;

  page_write_engine #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .DATA_W(DATA_W),
                      .TWR_TICKS(TWR)) u_page_write_engine (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .addr_vld_i(addr_vld),
    .addr_i(addr), .data_vld_i(data_vld), .data_i(data), .stop_i(stop),
    .wp_i(wp), .tick_i(tick), .arr_we_o(we), .arr_addr_o(waddr),
    .arr_data_o(wdata), .busy_o(busy));

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // array model, tick generator and tick accounting, all away from posedge
  always @(negedge clk) begin
    logic t;
    cycles++;
    if (rst_n && we) begin
      mem[waddr] = wdata;
      if (tick_seen != TWR) early_we++;
    end
    t = (div == 15);
    div = (div + 1) % 16;
    if (!busy) begin
      if (tick_seen != 0) last_ticks = tick_seen;
      tick_seen = 0;
    end else if (t) tick_seen++;
    tick = t;
  end

  task automatic pulse_start();
    @(negedge clk) start = 1; @(negedge clk) start = 0;
  endtask
  task automatic pulse_addr(input int a);
    @(negedge clk) begin addr = ADDR_W'(a); addr_vld = 1; end
    @(negedge clk) addr_vld = 0;
  endtask
  task automatic pulse_byte(input int d);
    @(negedge clk) begin data = DATA_W'(d); data_vld = 1; end
    @(negedge clk) data_vld = 0;
  endtask
  task automatic pulse_stop();
    @(negedge clk) stop = 1; @(negedge clk) stop = 0;
  endtask
  task automatic wait_idle();
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  function automatic int mem_errs();
    int e = 0;
    for (int k = 0; k < MEMSZ; k++) if (mem[k] !== exp_mem[k]) e++;
    return e;
  endfunction

  function automatic int pat(input int a, input int n, input int i);
    return ((a * 7 + i * 13 + n * 29) ^ 8'h5A) & 8'hFF;
  endfunction

  // full write; upd=1 updates the expected array
  task automatic page_cmd(input int a, input int n, input bit upd, input string req);
    int pg = a >> PAGE_W;
    pulse_start();
    pulse_addr(a);
    for (int i = 0; i < n; i++) begin
      pulse_byte(pat(a, n, i));
      if (upd) exp_mem[(pg << PAGE_W) | ((a + i) % PAGE)] = DATA_W'(pat(a, n, i));
    end
    @(negedge clk) stop = 1;
    @(negedge clk) stop = 0;
    check(busy == 1'b1, "R6 busy after stop", int'(busy), 1);
    early_we = 0;
    wait_idle();
    check(mem_errs() == 0, req, mem_errs(), 0);
    check(early_we == 0 && last_ticks == TWR, "R6 ticks before write", last_ticks, TWR);
  endtask

  initial begin
    int e;
    for (int k = 0; k < MEMSZ; k++) begin mem[k] = 8'hFF; exp_mem[k] = 8'hFF; end
    repeat (3) @(negedge clk);
    check(busy == 1'b0 && we == 1'b0, "R1 reset state", int'(busy), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(busy == 1'b0 && we == 1'b0, "R1 idle after reset", int'(we), 0);

    // R2 R3 R4: every offset with 1..PAGE+2 bytes
    for (int off = 0; off < PAGE; off++)
      for (int n = 1; n <= PAGE + 2; n++) begin
        int pg = (off * 3 + n) % (MEMSZ / PAGE);
        page_cmd((pg << PAGE_W) | off, n, 1'b1,
                 n > PAGE ? "R3 overwrite at wrap" : "R2 R4 wrap and partial page");
      end

    // R5: STOP without data
    pulse_start(); pulse_addr(9); pulse_stop();
    check(busy == 1'b0, "R5 stop without data", int'(busy), 0);
    // R5: restart discards buffered byte
    pulse_start(); pulse_addr(10); pulse_byte(8'h11); pulse_start(); pulse_stop();
    repeat (4) @(negedge clk);
    check(busy == 1'b0 && mem_errs() == 0, "R5 restart discards", mem_errs(), 0);

    // R7: wp high at stop
    pulse_start(); pulse_addr(20); pulse_byte(8'h22);
    @(negedge clk) begin stop = 1; wp = 1; end
    @(negedge clk) begin stop = 0; wp = 0; end
    check(busy == 1'b0, "R7 wp at stop", int'(busy), 0);
    // R7: wp at first byte strobe
    pulse_start(); pulse_addr(21);
    @(negedge clk) begin data = 8'h33; data_vld = 1; wp = 1; end
    @(negedge clk) begin data_vld = 0; wp = 0; end
    pulse_byte(8'h34); pulse_stop();
    check(busy == 1'b0, "R7 wp at first byte", int'(busy), 0);
    // R7: wp pulse between bytes
    pulse_start(); pulse_addr(22); pulse_byte(8'h44);
    @(negedge clk) wp = 1; @(negedge clk) wp = 0;
    pulse_byte(8'h45); pulse_stop();
    check(busy == 1'b0, "R7 wp inside window", int'(busy), 0);
    repeat (4) @(negedge clk);
    check(mem_errs() == 0, "R7 nothing written", mem_errs(), 0);

    // R8: wp high before first data byte only
    pulse_start();
    @(negedge clk) wp = 1;
    pulse_addr(30);
    @(negedge clk) wp = 0;
    pulse_byte(8'hA5); pulse_stop();
    exp_mem[30] = 8'hA5;
    check(busy == 1'b1, "R8 early wp ignored busy", int'(busy), 1);
    wait_idle();
    check(mem_errs() == 0, "R8 early wp ignored data", mem_errs(), 0);

    // R9: wp during wait aborts
    pulse_start(); pulse_addr(40); pulse_byte(8'h77); pulse_stop();
    repeat (3) @(negedge clk);
    wp = 1;
    @(negedge clk);
    check(busy == 1'b0, "R9 abort drops busy", int'(busy), 0);
    wp = 0;
    repeat (4) @(negedge clk);
    check(mem_errs() == 0, "R9 no write after abort", mem_errs(), 0);

    // R10: strobes while busy ignored
    pulse_start(); pulse_addr(50); pulse_byte(8'h5C); pulse_stop();
    exp_mem[50] = 8'h5C;
    pulse_start(); pulse_addr(51); pulse_byte(8'hC5); pulse_stop();
    check(busy == 1'b1, "R10 still busy", int'(busy), 1);
    wait_idle();
    e = mem_errs();
    check(e == 0, "R10 busy strobes ignored", e, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    failures++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule